// File: doc/BRIEF.md
# GPIO Interrupt Detection Controller

This block watches a bank of general-purpose input pins and turns chosen pin activity into interrupt requests. Every channel has its own detection mode: rising edge, falling edge, either edge, high level or low level. When a channel is enabled and its condition is seen, the channel's pending bit is set and stays set until software clears it by writing a one to that channel's bit in the clear register.

Each channel also has a mask bit. Masking and unmasking use two separate write-one registers, so software never needs a read-modify-write to change one channel. A masked channel still records events and still shows them in the status register. It only stops them from reaching the single combined interrupt line. Pins are brought into the clock domain through a two-stage synchronizer. Registers are reached through a plain 32-bit port: the write is strobed, and the read is combinational from the word address.

Register word addresses: 0 enable (read/write), 1 pending status (read only), 2 clear (write-one-to-clear, reads 0), 3 mask state (read only), 4 mask set (write-one), 5 mask clear (write-one), 6 mode word for channels 0 to 7, 7 mode word for channels 8 to 15.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, the enable, status and mode words all read 0, the mask word reads all ones in the low NCH bits, and irq_out is 0.
- R2: In mode code 1 (rising edge), a 0-to-1 change on an enabled channel's pin sets its status bit within three clock edges, and a 1-to-0 change does not set it.
- R3: In mode code 0 (falling edge), a 1-to-0 change sets the status bit, and a 0-to-1 change does not set it.
- R4: In mode code 4 (either edge), a change in either direction sets the status bit.
- R5: In mode code 3 (high level) or code 2 (low level), the status bit is set on every cycle the level is active, so clearing it while the level persists leaves it set.
- R6: A channel whose enable bit (address 0, bit n) is 0 never gets its status bit set.
- R7: Writing address 2 clears the status bit of every channel whose data bit is 1, and leaves channels whose data bit is 0 unchanged.
- R8: Writing address 4 masks every channel whose data bit is 1. Writing address 5 unmasks every channel whose data bit is 1. Zero bits leave the mask unchanged. Address 3 reads the mask.
- R9: irq_out is high exactly when some channel is both pending and unmasked. A masked pending bit stays visible in status and drives irq_out once the channel is unmasked.
- R10: When a detected event and a clear of the same channel fall in the same cycle, the status bit stays set.
- R11: Channel n keeps its 3-bit mode in bits [4n+2:4n] of address 6 for n < 8, and in bits [4(n-8)+2:4(n-8)] of address 7 for n >= 8. Bit 3 of each slot, and the slots of channels that do not exist, read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr (combinational) |
| pin_in | input | NCH | Asynchronous pin inputs |
| irq_out | output | 1 | Combined interrupt request (level) |

## Verification
The collision of interest is a detected pin event and a software clear of the same channel landing on the same clock edge. The bench times a rising pin so that the synchronized edge is seen in exactly the cycle whose closing edge also carries a clear write. It then expects the status bit to survive. A second clear one cycle later, with no event, must remove the bit. Level modes provoke the same collision on every clear, and the sweep judges them by requiring the bit to read back as set right after the clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int DW = 32;
    localparam int AW = 3;
    localparam int MW = 3;
    localparam int SLOT = 4;
    localparam int PER_WORD = DW / SLOT;

    typedef enum logic [MW-1:0] {
        MD_FALL = 3'd0,
        MD_RISE = 3'd1,
        MD_LOW  = 3'd2,
        MD_HIGH = 3'd3,
        MD_BOTH = 3'd4
    } det_mode_e;

    typedef enum logic [AW-1:0] {
        ADR_EN    = 3'd0,
        ADR_STAT  = 3'd1,
        ADR_CLR   = 3'd2,
        ADR_MASK  = 3'd3,
        ADR_MSET  = 3'd4,
        ADR_MCLR  = 3'd5,
        ADR_MODE0 = 3'd6,
        ADR_MODE1 = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic cur;
        logic prv;
    } pin_hist_t;

    function automatic logic detect_evt(input det_mode_e md, input pin_hist_t h);
        logic r;
        case (md)
            MD_FALL: r = h.prv & ~h.cur;
            MD_RISE: r = ~h.prv & h.cur;
            MD_LOW:  r = ~h.cur;
            MD_HIGH: r = h.cur;
            MD_BOTH: r = h.prv ^ h.cur;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync
    import gpio_irq_pkg::*;
#(
    parameter int NCH = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       pin_in,
    output pin_hist_t [NCH-1:0]  hist
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic meta_q;
        logic sync_q;
        logic prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_in[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign hist[g].cur = sync_q;
        assign hist[g].prv = prev_q;
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NCH = 12
) (
    input  det_mode_e [NCH-1:0]  mode,
    input  pin_hist_t [NCH-1:0]  hist,
    output logic [NCH-1:0]       ev
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ev[g] = detect_evt(mode[g], hist[g]);
    end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NCH = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wr_data,
    input  logic [NCH-1:0]       ev,
    output logic [NCH-1:0]       en,
    output logic [NCH-1:0]       pend,
    output logic [NCH-1:0]       mask,
    output det_mode_e [NCH-1:0]  mode,
    output logic [DW-1:0]        rd_data
);

    localparam int PAD = DW - NCH;

    logic [NCH-1:0] wbits;
    logic           wr_en_reg, wr_clr, wr_mset, wr_mclr, wr_md0, wr_md1;
    logic [DW-1:0]  md_word0, md_word1;

    assign wbits     = wr_data[NCH-1:0];
    assign wr_en_reg = wr_en && (addr == ADR_EN);
    assign wr_clr    = wr_en && (addr == ADR_CLR);
    assign wr_mset   = wr_en && (addr == ADR_MSET);
    assign wr_mclr   = wr_en && (addr == ADR_MCLR);
    assign wr_md0    = wr_en && (addr == ADR_MODE0);
    assign wr_md1    = wr_en && (addr == ADR_MODE1);

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= '0;
            pend <= '0;
            mask <= '1;
        end else begin
            if (wr_en_reg) en <= wbits;
            // a fresh event outranks a clear in the same cycle
            pend <= (pend & ~(wr_clr ? wbits : '0)) | (ev & en);
            mask <= (mask | (wr_mset ? wbits : '0)) & ~(wr_mclr ? wbits : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) mode[i] <= MD_FALL;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if ((i / PER_WORD == 0) ? wr_md0 : wr_md1)
                    mode[i] <= det_mode_e'(wr_data[SLOT*(i % PER_WORD) +: MW]);
            end
        end
    end

    always_comb begin
        md_word0 = '0;
        md_word1 = '0;
        for (int i = 0; i < NCH; i++) begin
            if (i / PER_WORD == 0) md_word0[SLOT*(i % PER_WORD) +: MW] = mode[i];
            else                   md_word1[SLOT*(i % PER_WORD) +: MW] = mode[i];
        end
    end

    always_comb begin
        case (addr)
            ADR_EN:    rd_data = {{PAD{1'b0}}, en};
            ADR_STAT:  rd_data = {{PAD{1'b0}}, pend};
            ADR_MASK:  rd_data = {{PAD{1'b0}}, mask};
            ADR_MODE0: rd_data = md_word0;
            ADR_MODE1: rd_data = md_word1;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NCH = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic [NCH-1:0]    pin_in,
    output logic              irq_out
);

    pin_hist_t [NCH-1:0] hist_w;
    det_mode_e [NCH-1:0] mode_w;
    logic [NCH-1:0]      ev_w;
    logic [NCH-1:0]      en_w;
    logic [NCH-1:0]      pend_w;
    logic [NCH-1:0]      mask_w;

    gpio_irq_sync #(.NCH(NCH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .hist   (hist_w)
    );

    gpio_irq_detect #(.NCH(NCH)) u_detect (
        .mode (mode_w),
        .hist (hist_w),
        .ev   (ev_w)
    );

    gpio_irq_regs #(.NCH(NCH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .ev      (ev_w),
        .en      (en_w),
        .pend    (pend_w),
        .mask    (mask_w),
        .mode    (mode_w),
        .rd_data (rd_data)
    );

    assign irq_out = |(pend_w & ~mask_w);

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int NCH = 12
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [AW-1:0]   addr,
    input logic [NCH-1:0]  wr_bits,
    input logic [NCH-1:0]  ev,
    input logic [NCH-1:0]  en,
    input logic [NCH-1:0]  pend,
    input logic [NCH-1:0]  mask
);

    // R6
    no_disabled_rise_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(en)) == '0));

    // R7
    clear_applies_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_CLR) |=> ((pend & $past(wr_bits & ~(ev & en))) == '0));

    // R10
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & $past(ev & en)) == $past(ev & en)));

    // R8
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADR_MSET) |=> ((mask & $past(wr_bits)) == $past(wr_bits)));

    // R8
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (addr == ADR_MSET || addr == ADR_MCLR)) |=> $stable(mask));

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.NCH(NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_bits (wr_data[NCH-1:0]),
    .ev      (ev_w),
    .en      (en_w),
    .pend    (pend_w),
    .mask    (mask_w)
);

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;

    localparam int NCH = 12;
    localparam logic [31:0] ALL = (32'd1 << NCH) - 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [2:0]     addr = 3'd0;
    logic [31:0]    wr_data = '0;
    logic [31:0]    rd_data;
    logic [NCH-1:0] pin = '0;
    logic           irq;
    int             n_chk = 0;
    int             n_err = 0;
    bit             done = 1'b0;

    gpio_irq_ctrl #(.NCH(NCH)) i_gpio_irq_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pin_in  (pin),
        .irq_out (irq)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d;
        rd(a, d);
        check(d == exp, req, d, exp);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_reg(3'd0, 32'd0, "R1 enable");
        expect_reg(3'd1, 32'd0, "R1 status");
        expect_reg(3'd3, ALL,   "R1 mask");
        expect_reg(3'd6, 32'd0, "R1 mode0");
        expect_reg(3'd7, 32'd0, "R1 mode1");
        check(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);

        // R11 slot layout and unused bits
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        expect_reg(3'd6, 32'h7777_7777, "R11 mode0 fields");
        expect_reg(3'd7, 32'h0000_7777, "R11 mode1 fields");
        wr(3'd6, 32'd0);
        wr(3'd7, 32'd0);

        // R8 mask set and clear
        wr(3'd5, 32'h005);
        expect_reg(3'd3, ALL & ~32'h005, "R8 mask clear");
        wr(3'd5, 32'h000);
        expect_reg(3'd3, ALL & ~32'h005, "R8 zero clear");
        wr(3'd4, 32'h001);
        expect_reg(3'd3, ALL & ~32'h004, "R8 mask set");
        wr(3'd4, 32'h000);
        expect_reg(3'd3, ALL & ~32'h004, "R8 zero set");
        wr(3'd5, ALL);
        expect_reg(3'd3, 32'd0, "R8 clear all");
        wr(3'd4, ALL);
        expect_reg(3'd3, ALL, "R8 set all");

        // R6 disabled channel
        wr(3'd6, 32'h1 << 12);
        wr(3'd0, 32'd0);
        @(negedge clk); pin[3] = 1'b1;
        idle(4);
        expect_reg(3'd1, 32'd0, "R6 disabled rise");
        pin[3] = 1'b0;
        idle(4);

        // R7 partial clear, R9 combined line
        wr(3'd6, 32'h0000_0110);
        wr(3'd0, 32'h6);
        wr(3'd2, ALL);
        @(negedge clk); pin[1] = 1'b1; pin[2] = 1'b1;
        idle(4);
        expect_reg(3'd1, 32'h6, "R7 both pending");
        check(irq == 1'b0, "R9 all masked", {31'd0, irq}, 32'd0);
        wr(3'd2, 32'h4);
        expect_reg(3'd1, 32'h2, "R7 clear one");
        wr(3'd2, 32'h0);
        expect_reg(3'd1, 32'h2, "R7 zero clear");
        wr(3'd5, 32'h2);
        idle(1);
        check(irq == 1'b1, "R9 unmask pending", {31'd0, irq}, 32'd1);
        wr(3'd2, 32'h2);
        idle(1);
        check(irq == 1'b0, "R9 after clear", {31'd0, irq}, 32'd0);
        wr(3'd4, ALL);
        pin = '0;
        wr(3'd0, 32'd0);
        idle(4);

        // R10 event and clear on the same edge
        wr(3'd6, 32'h1);
        wr(3'd0, 32'h1);
        wr(3'd2, ALL);
        @(negedge clk); pin[0] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        wr(3'd2, 32'h1);
        expect_reg(3'd1, 32'h1, "R10 event wins");
        wr(3'd2, 32'h1);
        expect_reg(3'd1, 32'h0, "R10 later clear");
        pin = '0;
        wr(3'd0, 32'd0);
        wr(3'd6, 32'd0);
        idle(4);

        // R2 R3 R4 R5 R9 R11 sweep over channels, modes and directions
        for (int ch = 0; ch < NCH; ch++) begin
            for (int md = 0; md < 5; md++) begin
                for (int v0 = 0; v0 < 2; v0++) begin
                    logic [2:0]  ma;
                    logic [31:0] mword;
                    logic [31:0] bitv;
                    bit          eb, ea;
                    string       req;
                    ma    = (ch < 8) ? 3'd6 : 3'd7;
                    mword = 32'(md) << (4 * (ch % 8));
                    bitv  = 32'd1 << ch;
                    case (md)
                        0: req = "R3";
                        1: req = "R2";
                        4: req = "R4";
                        default: req = "R5";
                    endcase
                    eb = (md == 2 && v0 == 0) || (md == 3 && v0 == 1);
                    ea = eb || (md == 4) ||
                         (md == 1 && v0 == 0) || (md == 0 && v0 == 1) ||
                         (md == 2 && v0 == 1) || (md == 3 && v0 == 0);

                    wr(3'd0, 32'd0);
                    pin = (v0 == 1) ? NCH'(bitv) : '0;
                    idle(4);
                    wr(ma, mword);
                    rd(ma, d);
                    check(d == mword, "R11 slot", d, mword);
                    wr(3'd0, bitv);
                    wr(3'd2, ALL);
                    idle(2);
                    rd(3'd1, d);
                    check(d == (eb ? bitv : 32'd0), {req, " before"}, d, eb ? bitv : 32'd0);
                    @(negedge clk); pin[ch] = ~pin[ch];
                    idle(4);
                    rd(3'd1, d);
                    check(d == (ea ? bitv : 32'd0), {req, " after"}, d, ea ? bitv : 32'd0);
                    check(irq == 1'b0, "R9 masked", {31'd0, irq}, 32'd0);
                    wr(3'd5, bitv);
                    idle(1);
                    check(irq == ea, "R9 unmasked", {31'd0, irq}, {31'd0, ea});
                    wr(3'd4, bitv);
                    wr(3'd0, 32'd0);
                    pin = '0;
                    wr(ma, 32'd0);
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule